// File: doc/BRIEF.md
# SD Card SPI Command Sequencer

This block is the host side of an SD card link in SPI mode. It makes the serial clock, the host-to-card data line and an active-low card select. The serial clock comes from the system clock through a divider that can be changed at run time, so the card can be driven slowly while it starts up and faster once it is running. After reset the block sends a run of synchronisation clocks on its own. Only after that does it accept requests.

Each request carries a six-byte command frame that the caller builds, including the CRC byte, and a one-cycle start strobe. The block runs one full transaction for it. First come idle clocks with the card deselected, then idle clocks with the card selected. The frame is shifted out next, and the block then polls for the one-byte response by sending all-ones bytes. Idle clocks follow with the card still selected, then the select is released and more idle clocks are sent. The block returns the response byte and a one-cycle completion pulse. It flags a poll that runs out, and it flags a returned byte that shows the bit stream is out of step.

Top module: `sd_spi_seq`

## Requirements
- R1: After reset the block sends exactly 80 serial clocks with `cs_n` high and `mosi` high, keeps `ready` low during them, and ignores `start` during them.
- R2: Each accepted transaction begins with exactly 8 serial clocks with `cs_n` high and `mosi` high, before `cs_n` falls.
- R3: After `cs_n` falls, the first 8 serial clocks carry `mosi` high. The first command bit is on the 9th clock.
- R4: The command goes out as six bytes, `cmd_frame[47:40]` first and `cmd_frame[7:0]` last, each byte MSB first. This is SPI mode 0: `mosi` changes only while `sclk` is low, and `miso` is sampled on the rising edge of `sclk`.
- R5: After the command the block polls with up to 8 bytes of 0xFF. The first received byte with bit 7 clear goes to `rsp_byte` and ends the poll. Bytes after it are not read.
- R6: A polled byte with bit 7 set that is not 0xFF ends the poll. It sets `align_err` and goes to `rsp_byte`.
- R7: If all 8 polled bytes are 0xFF, the block sets `timeout` and `rsp_byte` reads 0xFF. A valid byte on the 8th poll is a response, not a timeout.
- R8: After the response, the block sends 8 clocks with `cs_n` low and `mosi` high. It then raises `cs_n` and sends 8 clocks with `cs_n` high and `mosi` high. After that `done` is high for exactly one cycle and `ready` returns.
- R9: `start` is accepted only while `ready` is high. A strobe during a transaction starts nothing and does not change the frame being sent.
- R10: Each high and each low phase of `sclk` inside a byte lasts `div_ratio`+1 system clock cycles. Between transfers `sclk` rests low.
- R11: During reset, `cs_n`=1, `mosi`=1, `sclk`=0, `done`=0, `ready`=0, `timeout`=0, `align_err`=0 and `rsp_byte`=0xFF.
- R12: `rsp_byte`, `timeout` and `align_err` hold until the next accepted `start`, which clears them to 0xFF, 0 and 0.
- R13: `cs_n` changes only while `sclk` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| div_ratio | input | DIV_W | Serial clock half period minus one, in system cycles |
| cmd_frame | input | 48 | Command frame, first byte in bits 47:40 |
| start | input | 1 | One-cycle request strobe |
| miso | input | 1 | Card-to-host data |
| sclk | output | 1 | Serial clock to the card |
| mosi | output | 1 | Host-to-card data |
| cs_n | output | 1 | Active-low card select |
| ready | output | 1 | High when a start will be accepted |
| done | output | 1 | One-cycle pulse at transaction end |
| rsp_byte | output | 8 | Captured response byte |
| timeout | output | 1 | No response within the poll limit |
| align_err | output | 1 | Misaligned response byte seen |

## Verification
Two decisions can land on the same polled byte: ending the poll with a valid response, and ending it with a timeout because the poll count is used up. The bench places a byte with bit 7 clear exactly in the eighth poll slot. It expects the byte to be taken as the response with `timeout` low and the full eight poll bytes seen on `mosi`. A separate case that returns only 0xFF must raise `timeout` instead. A second overlap is a start strobe that arrives while a transaction is being shifted. The bench judges it by the card-side capture of the frame, by exactly one completion pulse, and by `cs_n` staying high afterwards.

// File: rtl/sd_spi_pkg.sv
package sd_spi_pkg;

    localparam int BYTE_W      = 8;
    localparam int FRAME_BYTES = 6;
    localparam int FRAME_W     = FRAME_BYTES * BYTE_W;
    localparam logic [BYTE_W-1:0] FILL_BYTE = 8'hFF;

    typedef enum logic [2:0] {
        ST_SYNC,
        ST_IDLE,
        ST_PRE_HI,
        ST_PRE_LO,
        ST_CMD,
        ST_POLL,
        ST_POST_LO,
        ST_POST_HI
    } seq_state_e;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              timeout;
        logic              misalign;
    } rsp_t;

    function automatic logic is_valid_rsp(logic [BYTE_W-1:0] b);
        return !b[BYTE_W-1];
    endfunction

    function automatic logic is_misaligned(logic [BYTE_W-1:0] b);
        return b[BYTE_W-1] && (b != FILL_BYTE);
    endfunction

    function automatic int cnt_width(int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/sd_sclk_tick.sv
module sd_sclk_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    output logic             sclk,
    output logic             rise_tick,
    output logic             fall_tick
);
    logic [DIV_W-1:0] cnt;
    logic             hit;

    assign hit       = run && (cnt >= half_div);
    assign rise_tick = hit && !sclk;
    assign fall_tick = hit && sclk;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt  <= '0;
            sclk <= 1'b0;
        end else if (hit) begin
            cnt  <= '0;
            sclk <= ~sclk;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/sd_spi_byte.sv
module sd_spi_byte
    import sd_spi_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              miso,
    input  logic [DIV_W-1:0]  half_div,
    output logic              sclk,
    output logic              mosi,
    output logic              byte_done,
    output logic [BYTE_W-1:0] rx_byte
);
    localparam int BW = cnt_width(BYTE_W);
    localparam logic [BW-1:0] LAST_BIT = BW'(BYTE_W - 1);

    logic              busy;
    logic [BYTE_W-1:0] tx_sh;
    logic [BYTE_W-1:0] rx_sh;
    logic [BW-1:0]     bit_idx;
    logic              rise_tick;
    logic              fall_tick;

    sd_sclk_tick #(.DIV_W(DIV_W)) u_tick (
        .clk       (clk),
        .rst       (rst),
        .run       (busy),
        .half_div  (half_div),
        .sclk      (sclk),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            byte_done <= 1'b0;
            tx_sh     <= FILL_BYTE;
            rx_sh     <= '0;
            bit_idx   <= '0;
        end else begin
            byte_done <= 1'b0;
            if (!busy) begin
                if (go && !byte_done) begin
                    busy    <= 1'b1;
                    tx_sh   <= tx_byte;
                    bit_idx <= '0;
                end
            end else begin
                if (rise_tick) begin
                    rx_sh <= {rx_sh[BYTE_W-2:0], miso};
                end
                if (fall_tick) begin
                    if (bit_idx == LAST_BIT) begin
                        busy      <= 1'b0;
                        byte_done <= 1'b1;
                        tx_sh     <= FILL_BYTE;
                    end else begin
                        tx_sh   <= {tx_sh[BYTE_W-2:0], 1'b1};
                        bit_idx <= bit_idx + 1'b1;
                    end
                end
            end
        end
    end

    assign mosi    = tx_sh[BYTE_W-1];
    assign rx_byte = rx_sh;

    // R4: data line only moves while the serial clock is low
    a_r4_mosi_stable_high: assert property (@(posedge clk) disable iff (rst)
        (sclk && $past(sclk)) |-> $stable(mosi));

    // R10: serial clock rests low whenever no byte is in flight
    a_r10_sclk_rest_low: assert property (@(posedge clk) disable iff (rst)
        (!busy && !$past(busy)) |-> !sclk);

endmodule

// File: rtl/sd_seq_fsm.sv
module sd_seq_fsm
    import sd_spi_pkg::*;
#(
    parameter int SYNC_CLKS = 80,
    parameter int POLL_MAX  = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [FRAME_W-1:0] cmd_frame,
    input  logic               byte_done,
    input  logic [BYTE_W-1:0]  rx_byte,
    output logic               go,
    output logic [BYTE_W-1:0]  tx_byte,
    output logic               cs_n,
    output logic               ready,
    output logic               done,
    output rsp_t               result
);
    localparam int SYNC_BYTES = (SYNC_CLKS + BYTE_W - 1) / BYTE_W;
    localparam int SW = cnt_width(SYNC_BYTES);
    localparam int PW = cnt_width(POLL_MAX);
    localparam int FW = cnt_width(FRAME_BYTES);
    localparam logic [SW-1:0] SYNC_LAST  = SW'(SYNC_BYTES - 1);
    localparam logic [PW-1:0] POLL_LAST  = PW'(POLL_MAX - 1);
    localparam logic [FW-1:0] FRAME_LAST = FW'(FRAME_BYTES - 1);

    seq_state_e         state;
    logic [SW-1:0]      sync_cnt;
    logic [PW-1:0]      poll_cnt;
    logic [FW-1:0]      cmd_idx;
    logic [FRAME_W-1:0] cmd_q;

    assign go      = (state != ST_IDLE);
    assign ready   = (state == ST_IDLE);
    assign tx_byte = (state == ST_CMD) ? cmd_q[FRAME_W-1 -: BYTE_W] : FILL_BYTE;
    assign cs_n    = !((state == ST_PRE_LO) || (state == ST_CMD) ||
                       (state == ST_POLL)   || (state == ST_POST_LO));

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_SYNC;
            sync_cnt <= '0;
            poll_cnt <= '0;
            cmd_idx  <= '0;
            cmd_q    <= '0;
            done     <= 1'b0;
            result   <= '{data: FILL_BYTE, timeout: 1'b0, misalign: 1'b0};
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_SYNC: if (byte_done) begin
                    if (sync_cnt == SYNC_LAST) state <= ST_IDLE;
                    else sync_cnt <= sync_cnt + 1'b1;
                end
                ST_IDLE: if (start) begin
                    cmd_q  <= cmd_frame;
                    result <= '{data: FILL_BYTE, timeout: 1'b0, misalign: 1'b0};
                    state  <= ST_PRE_HI;
                end
                ST_PRE_HI: if (byte_done) state <= ST_PRE_LO;
                ST_PRE_LO: if (byte_done) begin
                    cmd_idx <= '0;
                    state   <= ST_CMD;
                end
                ST_CMD: if (byte_done) begin
                    cmd_q <= {cmd_q[FRAME_W-BYTE_W-1:0], FILL_BYTE};
                    if (cmd_idx == FRAME_LAST) begin
                        poll_cnt <= '0;
                        state    <= ST_POLL;
                    end else begin
                        cmd_idx <= cmd_idx + 1'b1;
                    end
                end
                ST_POLL: if (byte_done) begin
                    if (is_valid_rsp(rx_byte)) begin
                        result.data <= rx_byte;
                        state       <= ST_POST_LO;
                    end else if (is_misaligned(rx_byte)) begin
                        result.data     <= rx_byte;
                        result.misalign <= 1'b1;
                        state           <= ST_POST_LO;
                    end else if (poll_cnt == POLL_LAST) begin
                        result.timeout <= 1'b1;
                        state          <= ST_POST_LO;
                    end else begin
                        poll_cnt <= poll_cnt + 1'b1;
                    end
                end
                ST_POST_LO: if (byte_done) state <= ST_POST_HI;
                ST_POST_HI: if (byte_done) begin
                    done  <= 1'b1;
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R8: completion is a single-cycle pulse
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: a strobe while polling never restarts the framing
    a_r9_no_restart: assert property (@(posedge clk) disable iff (rst)
        (state == ST_POLL && start) |=> (state != ST_PRE_HI));

    // R6, R7: a finished poll never reports both faults
    a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(result.timeout && result.misalign));

endmodule

// File: rtl/sd_spi_seq.sv
module sd_spi_seq
    import sd_spi_pkg::*;
#(
    parameter int DIV_W     = 8,
    parameter int SYNC_CLKS = 80,
    parameter int POLL_MAX  = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [DIV_W-1:0]   div_ratio,
    input  logic [FRAME_W-1:0] cmd_frame,
    input  logic               start,
    input  logic               miso,
    output logic               sclk,
    output logic               mosi,
    output logic               cs_n,
    output logic               ready,
    output logic               done,
    output logic [BYTE_W-1:0]  rsp_byte,
    output logic               timeout,
    output logic               align_err
);
    logic              go;
    logic              byte_done;
    logic [BYTE_W-1:0] tx_byte;
    logic [BYTE_W-1:0] rx_byte;
    rsp_t              result;

    sd_seq_fsm #(
        .SYNC_CLKS (SYNC_CLKS),
        .POLL_MAX  (POLL_MAX)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .cmd_frame (cmd_frame),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .go        (go),
        .tx_byte   (tx_byte),
        .cs_n      (cs_n),
        .ready     (ready),
        .done      (done),
        .result    (result)
    );

    sd_spi_byte #(.DIV_W(DIV_W)) u_byte (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .tx_byte   (tx_byte),
        .miso      (miso),
        .half_div  (div_ratio),
        .sclk      (sclk),
        .mosi      (mosi),
        .byte_done (byte_done),
        .rx_byte   (rx_byte)
    );

    assign rsp_byte  = result.data;
    assign timeout   = result.timeout;
    assign align_err = result.misalign;

    // R13: card select moves only with the serial clock low
    a_r13_cs_sclk_low: assert property (@(posedge clk) disable iff (rst)
        !$stable(cs_n) |-> !sclk);

    // R8: the completion pulse comes with the card deselected
    a_r8_done_deselected: assert property (@(posedge clk) disable iff (rst)
        done |-> (cs_n && !sclk));

endmodule

// File: tb/sd_spi_seq_tb_top.sv
module sd_spi_seq_tb_top;
    localparam int DIV_W    = 8;
    localparam int POLL_MAX = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [DIV_W-1:0] div_ratio = 8'd1;
    logic [47:0]      cmd_frame = '0;
    logic             miso = 1'b1;
    logic             sclk, mosi, cs_n, ready, done, timeout, align_err;
    logic [7:0]       rsp_byte;

    always #2 clk = ~clk;

    sd_spi_seq #(.DIV_W(DIV_W), .SYNC_CLKS(80), .POLL_MAX(POLL_MAX)) dut_i (
        .clk(clk), .rst(rst), .div_ratio(div_ratio), .cmd_frame(cmd_frame),
        .start(start), .miso(miso), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
        .ready(ready), .done(done), .rsp_byte(rsp_byte), .timeout(timeout),
        .align_err(align_err)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ---------------- card model ----------------
    logic [7:0] resp_tab [POLL_MAX];
    logic [7:0] got [32];
    logic [7:0] acc = 8'hFF;
    int nbytes = 0, rises_low = 0, pre_hi = 0, post_hi = 0;
    int in_sync = 1, sync_rises = 0, sync_bad = 0;

    function automatic logic [7:0] card_byte(input int idx);
        if (idx >= 7 && idx - 7 < POLL_MAX) return resp_tab[idx-7];
        return 8'hFF;
    endfunction

    always @(posedge sclk) begin
        if (in_sync != 0) begin
            sync_rises++;
            if (!mosi || !cs_n) sync_bad++;
        end
        if (!cs_n) begin
            acc = {acc[6:0], mosi};
            rises_low++;
            if (rises_low % 8 == 0) begin
                if (nbytes < 32) got[nbytes] = acc;
                nbytes++;
            end
        end else if (rises_low == 0) begin
            pre_hi++;
        end else begin
            post_hi++;
        end
    end

    always @(negedge sclk or negedge cs_n or posedge cs_n) begin
        logic [7:0] b;
        int n;
        if (cs_n) miso = 1'b1;
        else begin
            n = rises_low;
            b = card_byte(n / 8);
            miso = b[7 - (n % 8)];
        end
    end

    // ---------------- port-level monitors ----------------
    int cs_bad = 0, mosi_bad = 0, hi_run = 0, last_hi = 0;
    logic prev_sclk = 1'b0, prev_mosi = 1'b1, prev_cs = 1'b1;
    always @(negedge clk) begin
        if (!rst) begin
            if (cs_n !== prev_cs && sclk) cs_bad++;
            if (sclk && prev_sclk && mosi !== prev_mosi) mosi_bad++;
            if (sclk) hi_run++;
            else if (hi_run > 0) begin last_hi = hi_run; hi_run = 0; end
        end
        prev_sclk = sclk; prev_mosi = mosi; prev_cs = cs_n;
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        logic [47:0] frame;
        logic [7:0]  rsp;
        logic        to;
        logic        err;
        int          npoll;
    } exp_t;
    exp_t q[$];
    int ndone = 0;

    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (done) begin
                if (q.size() == 0) begin
                    chk("R9", "unexpected done", 1, 0);
                end else begin
                    e = q.pop_front();
                    chk("R5", "rsp_byte", rsp_byte, e.rsp);
                    chk("R7", "timeout", timeout, e.to);
                    chk("R6", "align_err", align_err, e.err);
                    chk("R2", "pre-select clocks", pre_hi, 8);
                    chk("R3", "first selected byte", got[0], 8'hFF);
                    for (int k = 0; k < 6; k++)
                        chk("R4", "command byte", got[1+k], e.frame[47-8*k -: 8]);
                    for (int k = 0; k < e.npoll; k++)
                        chk("R5", "poll byte on mosi", got[7+k], 8'hFF);
                    chk("R8", "selected byte count", nbytes, 8 + e.npoll);
                    chk("R8", "trailing selected byte", got[7+e.npoll], 8'hFF);
                    chk("R8", "deselected trailing clocks", post_hi, 8);
                    chk("R8", "cs_n at done", cs_n, 1);
                end
                ndone++;
                @(negedge clk);
                chk("R8", "done width", done, 0);
                chk("R8", "ready after done", ready, 1);
            end
        end
    end

    task automatic set_resp(input logic [7:0] r0, input logic [7:0] r1,
                            input int pos_last, input logic [7:0] rl);
        for (int k = 0; k < POLL_MAX; k++) resp_tab[k] = 8'hFF;
        resp_tab[0] = r0;
        resp_tab[1] = r1;
        if (pos_last >= 0) resp_tab[pos_last] = rl;
    endtask

    task automatic run_txn(input logic [47:0] f, input logic [7:0] ersp,
                           input logic eto, input logic eerr, input int npoll,
                           input bit stray);
        exp_t e;
        int d0;
        while (!ready) @(negedge clk);
        rises_low = 0; nbytes = 0; pre_hi = 0; post_hi = 0;
        e.frame = f; e.rsp = ersp; e.to = eto; e.err = eerr; e.npoll = npoll;
        q.push_back(e);
        d0 = ndone;
        cmd_frame = f; start = 1'b1;
        @(negedge clk);
        start = 1'b0; cmd_frame = '0;
        chk("R12", "timeout cleared on start", timeout, 0);
        chk("R12", "align_err cleared on start", align_err, 0);
        chk("R12", "rsp_byte cleared on start", rsp_byte, 8'hFF);
        chk("R9", "ready low when busy", ready, 0);
        if (stray) begin
            repeat (200) @(negedge clk);
            cmd_frame = 48'hDEAD_BEEF_0F0F; start = 1'b1;
            @(negedge clk);
            start = 1'b0; cmd_frame = '0;
        end
        while (ndone == d0) @(negedge clk);
        @(negedge clk);
    endtask

    // ---------------- main sequence ----------------
    initial begin
        for (int k = 0; k < POLL_MAX; k++) resp_tab[k] = 8'hFF;
        repeat (3) @(negedge clk);
        chk("R11", "cs_n in reset", cs_n, 1);
        chk("R11", "mosi in reset", mosi, 1);
        chk("R11", "sclk in reset", sclk, 0);
        chk("R11", "done in reset", done, 0);
        chk("R11", "ready in reset", ready, 0);
        chk("R11", "flags in reset", {timeout, align_err}, 0);
        chk("R11", "rsp_byte in reset", rsp_byte, 8'hFF);
        rst = 1'b0;

        // R1: strobe during the synchronisation clocks is ignored
        repeat (40) @(negedge clk);
        cmd_frame = 48'h4000_0000_0095; start = 1'b1;
        @(negedge clk);
        start = 1'b0; cmd_frame = '0;
        while (!ready) @(negedge clk);
        in_sync = 0;
        chk("R1", "sync clock count", sync_rises, 80);
        chk("R1", "sync clocks with cs_n/mosi low", sync_bad, 0);
        repeat (50) @(negedge clk);
        chk("R1", "start during sync ignored (done count)", ndone, 0);
        chk("R1", "start during sync ignored (cs_n)", cs_n, 1);
        chk("R10", "high phase at ratio 1", last_hi, 2);

        // R5: response after two busy bytes
        set_resp(8'hFF, 8'hFF, 2, 8'h01);
        run_txn(48'h4000_0000_0095, 8'h01, 0, 0, 3, 0);

        // R5: immediate response, later bytes not read
        set_resp(8'h00, 8'h05, -1, 8'hFF);
        run_txn(48'h4800_0001_AA87, 8'h00, 0, 0, 1, 0);

        // R6: misaligned byte
        set_resp(8'hFF, 8'hC1, 2, 8'h01);
        run_txn(48'h7700_0000_0065, 8'hC1, 0, 1, 2, 0);
        repeat (60) @(negedge clk);
        chk("R12", "align_err held", align_err, 1);
        chk("R12", "rsp_byte held", rsp_byte, 8'hC1);

        // R7: no response in the poll window
        set_resp(8'hFF, 8'hFF, -1, 8'hFF);
        run_txn(48'h7A00_0000_00FD, 8'hFF, 1, 0, 8, 0);

        // R7: valid byte on the last permitted poll
        set_resp(8'hFF, 8'hFF, 7, 8'h3E);
        run_txn(48'h6900_0000_0077, 8'h3E, 0, 0, 8, 0);

        // R9: stray strobe while shifting
        set_resp(8'h01, 8'hFF, -1, 8'hFF);
        begin
            int d1;
            run_txn(48'h5112_3456_7801, 8'h01, 0, 0, 1, 1);
            d1 = ndone;
            repeat (100) @(negedge clk);
            chk("R9", "no extra transaction", ndone, d1);
            chk("R9", "cs_n idle after stray", cs_n, 1);
        end

        // R10: slower serial clock
        div_ratio = 8'd3;
        set_resp(8'hFF, 8'h00, -1, 8'hFF);
        run_txn(48'h4000_0000_0095, 8'h00, 0, 0, 2, 0);
        chk("R10", "high phase at ratio 3", last_hi, 4);
        chk("R10", "sclk rests low", sclk, 0);

        chk("R13", "cs_n changes with sclk high", cs_bad, 0);
        chk("R4", "mosi changes with sclk high", mosi_bad, 0);
        chk("R9", "scoreboard drained", q.size(), 0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hang expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule